// File: doc/BRIEF.md
# XGMII Link Fault Guard

This block sits on the transmit side of a 10 Gb/s Ethernet MAC, between the MAC's transmit datapath and the XGMII transmit port. It also watches the XGMII receive stream. Both buses are 64 data bits wide with one control bit per byte lane, so each clock carries two 32-bit columns. When the receive side reports a fault ordered set, the block takes over the transmit port. A local fault makes it send remote fault columns, which tell the link partner about the problem. A remote fault makes it send idle columns. In both cases any packet that is in flight is cut off at once.

Every received column that is not a fault ordered set counts toward recovery. The fault state is released only after 128 such columns arrive in a row with no fault ordered set among them. Until then, no transmit data from the MAC reaches the port. With no fault in effect, transmit data and control pass through one register stage unchanged. The current fault state is shown on two flags.

Top module: `xgmii_fault_guard`

## Requirements
- R1: With no fault in effect, `tx_out_data`/`tx_out_ctrl` equal `tx_in_data`/`tx_in_ctrl` of the previous clock (one register of latency).
- R2: Byte lane k is data bits [8k+7:8k] with control bit k. A received column is a fault ordered set when all of the following hold: its first lane is 0x9C with its control bit set, its second and third lanes are 0x00, and its fourth lane is 0x01 (local fault) or 0x02 (remote fault). The control bits of the other three lanes are not examined. Any other column is an ordinary column.
- R3: Column 0 (lanes 0-3) and column 1 (lanes 4-7) are checked independently. A fault ordered set in either column takes effect.
- R4: From the clock after a local fault ordered set is received, `local_fault_o` is 1. Every transmitted column is then the remote fault column: lanes 0x9C,0x00,0x00,0x02 with control 4'b0001.
- R5: From the clock after a remote fault ordered set is received, and while no local fault has been seen in that word, `remote_fault_o` is 1. Every transmitted column is then the idle column: four lanes of 0x07 with control 4'b1111.
- R6: The most recently received fault type decides the state. If one received word holds both types, local fault wins.
- R7: A packet in flight is overridden starting with the clock after the fault arrives. No MAC transmit bytes appear while a fault is in effect.
- R8: A fault ordered set resets the count of ordinary columns to zero. Each ordinary column adds one, with column 0 counted before column 1. The fault clears as soon as the count reaches 128, and 127 columns are not enough. Pass-through resumes in the same clock that the flags drop.
- R9: While `rst_n` is low, both flags are 0 and the transmit port carries idle columns.
- R10: `local_fault_o` and `remote_fault_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 64 | XGMII receive data |
| rx_ctrl | input | 8 | XGMII receive control, one bit per lane |
| tx_in_data | input | 64 | Transmit data from the MAC |
| tx_in_ctrl | input | 8 | Transmit control from the MAC |
| tx_out_data | output | 64 | XGMII transmit data |
| tx_out_ctrl | output | 8 | XGMII transmit control |
| local_fault_o | output | 1 | Local fault in effect (remote fault columns sent) |
| remote_fault_o | output | 1 | Remote fault in effect (idle columns sent) |

## Verification
The assertions check several rules on every clock. The flags are never both set. A received fault ordered set raises the matching flag on the next clock. Each flag forces its replacement pattern onto the port. With no flag set, the port carries the previous clock's MAC input. A flag only drops after a word that held no fault ordered set. Some behaviours need a long sequence to show, and only the bench scenarios cover them. These are the exact 127/128 column threshold and its dependence on which column held the last fault, the restart of the count when a fault returns mid-recovery, the near-miss columns that must not count as faults, and the handover between fault types.

// File: rtl/xfg_pkg.sv
// Shared constants and types for the XGMII link fault guard.
// Assumes lane k occupies data bits [8k+7:8k] with control bit k.
package xfg_pkg;
    localparam int          COL_LANES = 4;
    localparam logic [7:0]  SEQ_CHAR  = 8'h9C;
    localparam logic [7:0]  IDLE_CHAR = 8'h07;
    localparam logic [7:0]  LF_CODE   = 8'h01;
    localparam logic [7:0]  RF_CODE   = 8'h02;

    typedef enum logic [1:0] {
        LINK_OK     = 2'd0,
        LINK_LOCAL  = 2'd1,
        LINK_REMOTE = 2'd2
    } link_state_e;
endpackage

// File: rtl/xfg_col_detect.sv
// Classifies one received 32-bit column as local fault, remote fault or
// ordinary. Purely combinational; control bits of lanes 1..3 are ignored.
module xfg_col_detect
    import xfg_pkg::*;
(
    input  logic [31:0] col_data,
    input  logic [3:0]  col_ctrl,
    output logic        is_local,
    output logic        is_remote
);
    logic head_ok;

    // Common part of a fault ordered set: sequence char in lane 0, zero lanes 1-2
    always_comb begin
        head_ok   = col_ctrl[0] && (col_data[7:0] == SEQ_CHAR)
                    && (col_data[23:8] == 16'h0000);
        is_local  = head_ok && (col_data[31:24] == LF_CODE);
        is_remote = head_ok && (col_data[31:24] == RF_CODE);
    end
endmodule

// File: rtl/xfg_fault_fsm.sv
// Tracks the fault state from per-column fault flags. Counts consecutive
// ordinary columns in column order and clears the fault at CLEAR_COLS.
// Assumes col_local/col_remote are never both set for one column.
module xfg_fault_fsm
    import xfg_pkg::*;
#(
    parameter int NCOL       = 2,
    parameter int CLEAR_COLS = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCOL-1:0] col_local,
    input  logic [NCOL-1:0] col_remote,
    output link_state_e     state_next,
    output link_state_e     state_q
);
    localparam int             CW    = $clog2(CLEAR_COLS + 1);
    localparam logic [CW-1:0]  LIMIT = CW'(CLEAR_COLS);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_v;
    logic          lseen;
    logic          rseen;

    // Walk the columns in order: fault resets the count, ordinary column adds one
    always_comb begin
        cnt_v = cnt_q;
        lseen = 1'b0;
        rseen = 1'b0;
        for (int c = 0; c < NCOL; c++) begin
            if (col_local[c]) begin
                cnt_v = '0;
                lseen = 1'b1;
            end else if (col_remote[c]) begin
                cnt_v = '0;
                rseen = 1'b1;
            end else if (cnt_v < LIMIT) begin
                cnt_v = cnt_v + 1'b1;
            end
        end
    end

    // Next state: local wins, then remote, then release after the clean run
    always_comb begin
        if (lseen)
            state_next = LINK_LOCAL;
        else if (rseen)
            state_next = LINK_REMOTE;
        else if (state_q != LINK_OK && cnt_v >= LIMIT)
            state_next = LINK_OK;
        else
            state_next = state_q;
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_OK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_next;
            cnt_q   <= cnt_v;
        end
    end
endmodule

// File: rtl/xfg_tx_mux.sv
// Output register of the transmit port: passes MAC data through or replaces
// every column with the pattern for the selected fault state.
module xfg_tx_mux
    import xfg_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  link_state_e        sel,
    input  logic [8*LANES-1:0] in_data,
    input  logic [LANES-1:0]   in_ctrl,
    output logic [8*LANES-1:0] out_data,
    output logic [LANES-1:0]   out_ctrl
);
    localparam int NCOL = LANES / COL_LANES;

    logic [8*LANES-1:0] rf_data;
    logic [LANES-1:0]   rf_ctrl;
    logic [8*LANES-1:0] idle_data;

    // Replacement patterns repeated once per column
    for (genvar c = 0; c < NCOL; c++) begin : g_pat
        assign rf_data[32*c +: 32]   = {RF_CODE, 16'h0000, SEQ_CHAR};
        assign rf_ctrl[4*c +: 4]     = 4'b0001;
        assign idle_data[32*c +: 32] = {4{IDLE_CHAR}};
    end

    // Registered selection of the transmit word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= idle_data;
            out_ctrl <= '1;
        end else begin
            case (sel)
                LINK_LOCAL: begin
                    out_data <= rf_data;
                    out_ctrl <= rf_ctrl;
                end
                LINK_REMOTE: begin
                    out_data <= idle_data;
                    out_ctrl <= '1;
                end
                default: begin
                    out_data <= in_data;
                    out_ctrl <= in_ctrl;
                end
            endcase
        end
    end
endmodule

// File: rtl/xgmii_fault_guard.sv
// XGMII link fault guard: detects fault ordered sets on the receive stream
// and overrides the transmit port until CLEAR_COLS ordinary columns arrive.
// Assumes LANES is a multiple of four.
module xgmii_fault_guard
    import xfg_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int CLEAR_COLS = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [8*LANES-1:0] rx_data,
    input  logic [LANES-1:0]   rx_ctrl,
    input  logic [8*LANES-1:0] tx_in_data,
    input  logic [LANES-1:0]   tx_in_ctrl,
    output logic [8*LANES-1:0] tx_out_data,
    output logic [LANES-1:0]   tx_out_ctrl,
    output logic               local_fault_o,
    output logic               remote_fault_o
);
    localparam int NCOL = LANES / COL_LANES;

    logic [NCOL-1:0] col_local;
    logic [NCOL-1:0] col_remote;
    link_state_e     state_next;
    link_state_e     state_q;

    // One detector per received column
    for (genvar c = 0; c < NCOL; c++) begin : g_det
        xfg_col_detect u_det (
            .col_data  (rx_data[32*c +: 32]),
            .col_ctrl  (rx_ctrl[4*c +: 4]),
            .is_local  (col_local[c]),
            .is_remote (col_remote[c])
        );
    end

    xfg_fault_fsm #(.NCOL(NCOL), .CLEAR_COLS(CLEAR_COLS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .col_local  (col_local),
        .col_remote (col_remote),
        .state_next (state_next),
        .state_q    (state_q)
    );

    xfg_tx_mux #(.LANES(LANES)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (state_next),
        .in_data  (tx_in_data),
        .in_ctrl  (tx_in_ctrl),
        .out_data (tx_out_data),
        .out_ctrl (tx_out_ctrl)
    );

    // Status flags decoded from the registered state
    always_comb begin
        local_fault_o  = (state_q == LINK_LOCAL);
        remote_fault_o = (state_q == LINK_REMOTE);
    end
endmodule

// File: rtl/xfg_chk.sv
// Property checker for xgmii_fault_guard, attached with bind below.
module xfg_chk #(
    parameter int LANES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [8*LANES-1:0] rx_data,
    input logic [LANES-1:0]   rx_ctrl,
    input logic [8*LANES-1:0] tx_in_data,
    input logic [LANES-1:0]   tx_in_ctrl,
    input logic [8*LANES-1:0] tx_out_data,
    input logic [LANES-1:0]   tx_out_ctrl,
    input logic               local_fault_o,
    input logic               remote_fault_o
);
    localparam int NCOL = LANES / 4;

    logic               any_lf;
    logic               any_rf;
    logic [8*LANES-1:0] pat_rf_d;
    logic [LANES-1:0]   pat_rf_c;
    logic [8*LANES-1:0] pat_idle_d;

    // Independent scan of the receive word for fault ordered sets
    always_comb begin
        any_lf = 1'b0;
        any_rf = 1'b0;
        for (int c = 0; c < NCOL; c++) begin
            if (rx_ctrl[4*c] && rx_data[32*c +: 32] == 32'h0100009C) any_lf = 1'b1;
            if (rx_ctrl[4*c] && rx_data[32*c +: 32] == 32'h0200009C) any_rf = 1'b1;
            pat_rf_d[32*c +: 32]   = 32'h0200009C;
            pat_rf_c[4*c +: 4]     = 4'h1;
            pat_idle_d[32*c +: 32] = 32'h07070707;
        end
    end

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(local_fault_o && remote_fault_o));

    // R4
    local_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_lf |=> local_fault_o);

    // R6
    remote_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rf && !any_lf) |=> remote_fault_o);

    // R4
    rf_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        local_fault_o |-> (tx_out_data == pat_rf_d && tx_out_ctrl == pat_rf_c));

    // R5
    idle_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remote_fault_o |-> (tx_out_data == pat_idle_d && tx_out_ctrl == '1));

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !local_fault_o && !remote_fault_o)
        |-> (tx_out_data == $past(tx_in_data) && tx_out_ctrl == $past(tx_in_ctrl)));

    // R8
    clean_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(local_fault_o || remote_fault_o) |-> $past(!any_lf && !any_rf));
endmodule

bind xgmii_fault_guard xfg_chk #(.LANES(LANES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_data        (rx_data),
    .rx_ctrl        (rx_ctrl),
    .tx_in_data     (tx_in_data),
    .tx_in_ctrl     (tx_in_ctrl),
    .tx_out_data    (tx_out_data),
    .tx_out_ctrl    (tx_out_ctrl),
    .local_fault_o  (local_fault_o),
    .remote_fault_o (remote_fault_o)
);

// File: tb/tb_xgmii_fault_guard.sv
// Bench for xgmii_fault_guard: behavioural reference model compared every clock.
module tb_xgmii_fault_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] rx_data = '0;
    logic [7:0]  rx_ctrl = '0;
    logic [63:0] tx_in_data = '0;
    logic [7:0]  tx_in_ctrl = '0;
    logic [63:0] tx_out_data;
    logic [7:0]  tx_out_ctrl;
    logic        local_fault_o;
    logic        remote_fault_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state: 0 none, 1 local, 2 remote
    int m_state = 0;
    int m_cnt = 0;

    localparam logic [31:0] LF_COL   = 32'h0100009C;
    localparam logic [31:0] RF_COL   = 32'h0200009C;
    localparam logic [31:0] IDLE_COL = 32'h07070707;

    always #5 clk = ~clk;

    xgmii_fault_guard dut (
        .clk(clk), .rst_n(rst_n),
        .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .tx_in_data(tx_in_data), .tx_in_ctrl(tx_in_ctrl),
        .tx_out_data(tx_out_data), .tx_out_ctrl(tx_out_ctrl),
        .local_fault_o(local_fault_o), .remote_fault_o(remote_fault_o)
    );

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference classification of one 32-bit column: 1 local, 2 remote, 0 ordinary
    function automatic int kind(input logic [31:0] d, input logic c0);
        if (!c0 || d[7:0] != 8'h9C || d[15:8] != 0 || d[23:16] != 0) return 0;
        if (d[31:24] == 8'h01) return 1;
        if (d[31:24] == 8'h02) return 2;
        return 0;
    endfunction

    // Drive one word, advance a clock, update the model and compare outputs
    task automatic step(input logic [63:0] rd, input logic [7:0] rc,
                        input logic [63:0] td, input logic [7:0] tc);
        bit l = 0, r = 0;
        logic [63:0] ed;
        logic [7:0]  ec;
        string tg;
        @(negedge clk);
        rx_data = rd; rx_ctrl = rc; tx_in_data = td; tx_in_ctrl = tc;
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            int k = kind(rd[32*c +: 32], rc[4*c]);
            if (k == 1) begin m_cnt = 0; l = 1; end
            else if (k == 2) begin m_cnt = 0; r = 1; end
            else if (m_cnt < 128) m_cnt++;
        end
        if (l) m_state = 1;
        else if (r) m_state = 2;
        else if (m_cnt >= 128) m_state = 0;
        #1;
        if (m_state == 1) begin ed = {RF_COL, RF_COL}; ec = 8'h11; tg = "R4"; end
        else if (m_state == 2) begin ed = {IDLE_COL, IDLE_COL}; ec = 8'hFF; tg = "R5"; end
        else begin ed = td; ec = tc; tg = "R1"; end
        check(tx_out_data == ed && tx_out_ctrl == ec, tg,
              {tx_out_ctrl, tx_out_data}, {ec, ed});
        check(local_fault_o == (m_state == 1) && remote_fault_o == (m_state == 2),
              "R10 flags", {70'd0, local_fault_o, remote_fault_o},
              {70'd0, m_state == 1, m_state == 2});
    endtask

    task automatic clean(input int n);
        for (int i = 0; i < n; i++)
            step({IDLE_COL, IDLE_COL}, 8'hFF, {$urandom, $urandom}, 8'($urandom));
    endtask

    task automatic flag_chk(input bit el, input bit er, input string tag);
        check(local_fault_o == el && remote_fault_o == er, tag,
              {70'd0, local_fault_o, remote_fault_o}, {70'd0, el, er});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: idle output and clear flags while in reset
        check(tx_out_data == {IDLE_COL, IDLE_COL} && tx_out_ctrl == 8'hFF, "R9 out",
              {tx_out_ctrl, tx_out_data}, {8'hFF, IDLE_COL, IDLE_COL});
        flag_chk(0, 0, "R9 flags");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: random pass-through
        clean(20);

        // R2: near misses (wrong code, lane0 control clear, nonzero lane 1)
        step({IDLE_COL, 32'h0300009C}, 8'hF1, 64'h1122334455667788, 8'h00);
        step({32'h0100009C, IDLE_COL}, 8'h0F, 64'h99AABBCCDDEEFF00, 8'h00);
        step({IDLE_COL, 32'h0100019C}, 8'hF1, 64'h0102030405060708, 8'h00);
        flag_chk(0, 0, "R2 near miss");
        // R2: lanes 1-3 control bits ignored
        step({IDLE_COL, RF_COL}, 8'hFF, 64'h0, 8'h00);
        flag_chk(0, 1, "R2 ctrl ignored");
        clean(64);
        flag_chk(0, 0, "R8 clear after remote");

        // R3: local fault in column 1, then 63 clean words = 126 columns
        step({LF_COL, IDLE_COL}, 8'h1F, 64'h0, 8'h00);
        flag_chk(1, 0, "R3 column 1");
        clean(63);
        flag_chk(1, 0, "R8 126 columns");
        clean(1);
        flag_chk(0, 0, "R8 128 columns");

        // R8: local fault in column 0 only -> 1 + 126 = 127 columns, not enough
        step({IDLE_COL, LF_COL}, 8'hF1, 64'h0, 8'h00);
        flag_chk(1, 0, "R3 column 0");
        clean(63);
        flag_chk(1, 0, "R8 127 columns");
        clean(1);
        flag_chk(0, 0, "R8 release");

        // R7: packet in flight overridden by remote fault
        step({IDLE_COL, IDLE_COL}, 8'hFF, 64'hD5555555555555FB, 8'h01);
        step({IDLE_COL, IDLE_COL}, 8'hFF, 64'hA1A2A3A4A5A6A7A8, 8'h00);
        step({RF_COL, IDLE_COL}, 8'h1F, 64'hB1B2B3B4B5B6B7B8, 8'h00);
        check(tx_out_data != 64'hB1B2B3B4B5B6B7B8 && tx_out_data == {IDLE_COL, IDLE_COL},
              "R7 override", {tx_out_ctrl, tx_out_data}, {8'hFF, IDLE_COL, IDLE_COL});
        step({IDLE_COL, IDLE_COL}, 8'hFF, 64'hC1C2C3C4C5C6C7C8, 8'h00);
        check(tx_out_data == {IDLE_COL, IDLE_COL}, "R7 no packet bytes",
              {tx_out_ctrl, tx_out_data}, {8'hFF, IDLE_COL, IDLE_COL});
        clean(70);

        // R6: both types in one word, either order -> local
        step({LF_COL, RF_COL}, 8'h11, 64'h0, 8'h00);
        flag_chk(1, 0, "R6 both A");
        step({RF_COL, LF_COL}, 8'h11, 64'h0, 8'h00);
        flag_chk(1, 0, "R6 both B");
        // R6: later remote replaces local
        step({IDLE_COL, RF_COL}, 8'hF1, 64'h0, 8'h00);
        flag_chk(0, 1, "R6 remote after local");
        step({IDLE_COL, LF_COL}, 8'hF1, 64'h0, 8'h00);
        flag_chk(1, 0, "R6 local after remote");

        // R8: fault mid-recovery restarts the count
        clean(40);
        step({IDLE_COL, RF_COL}, 8'hF1, 64'h0, 8'h00);
        clean(40);
        flag_chk(0, 1, "R8 restart");
        clean(30);
        flag_chk(0, 0, "R8 cleared after restart");
        clean(10);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule